// File: doc/BRIEF.md
# Staged RTC Register Front End with Write Protection

This block is the host-side register front end of a real-time clock. A simple memory-mapped bus writes into holding registers; nothing reaches the active copies that the timekeeping domain uses until software writes the commit register. A commit runs for a fixed number of cycles. While it runs, a busy bit is visible in the control word. The active copies are updated on the cycle the busy bit falls.

Three guards protect the register file. Time and alarm fields accept writes only after a two-word unlock sequence has been committed to the protection register. Control-word writes act only when they carry a key byte. The pair of power-key registers accepts writes only after both configuration words have been written and committed. A power-lost output stays high until both power keys hold their magic values in the active copy. Bus reads always return active values, never staged ones. Calendar counting lies outside this block.

Top module: `rtc_fe_top`

Register words, by byte offset: control 0x00; time fields 0x10 to 0x28; alarm fields 0x30 to 0x48; power key A 0x4C; power key B 0x50; configuration words 0x5C and 0x60; protection 0x70; commit 0x78. Only word-aligned addresses (low two bits zero) select a register.

## Requirements
- R1: After reset, commit_busy is 0, wr_unlocked is 0, power_lost is 1, and every register reads 0 except for the busy bit of the control word.
- R2: A write of exactly 16'h0001 to offset 0x78 starts a commit. commit_busy and control read bit 6 are then 1 for BUSY_CYCLES cycles, 4 by default. Any other value written there starts nothing.
- R3: A commit request made while commit_busy is 1 is ignored, and the busy period is not extended.
- R4: A write lands in the holding copy only. Reads show the new value only after the following commit has finished.
- R5: Committing 16'h9136 to offset 0x70 and then, in a later commit, 16'h586A sets wr_unlocked to 1.
- R6: Any other committed protection value, or the two words in the reverse order, leaves or returns the unlock state at locked.
- R7: While wr_unlocked is 0, writes to the time and alarm words are dropped, and a later commit does not change them.
- R8: A control-word write acts only when bits 15:8 equal 8'h43. With the key present, bit 4 clears both power keys, holding and active copies, at once.
- R9: With the key present, control bit 5 reloads every holding copy from its active copy, so that previously staged writes are discarded.
- R10: power_lost is 0 only while active power key A equals 16'hA357 and active power key B equals 16'h67D2.
- R11: Power-key writes are dropped until both configuration words (0x5C and 0x60) have been written and a commit has completed after those writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | AW (7) | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (active copy) for bus_addr, combinational |
| commit_busy | output | 1 | Commit transfer in progress |
| power_lost | output | 1 | Power keys not valid |
| wr_unlocked | output | 1 | Time and alarm writes enabled |

## Verification
The hardest state to reach from the ports is a set of power keys that is accepted. To get there the bench has to write both configuration words, commit, and only then write both keys and commit again. A bench that writes the keys first sees them silently dropped. The bench goes through this gate twice, once in the wrong order and once in the right one. It also places a second commit request inside the busy window of the first and checks on which cycle busy falls, which shows that the request was ignored rather than used to restart the window.

// File: rtl/rtc_fe_pkg.sv
package rtc_fe_pkg;
  localparam int DW = 16;
  localparam int FIELDS = 7;

  // word indices (byte offset / 4)
  localparam int W_CTRL   = 0;
  localparam int W_TIME0  = 4;
  localparam int W_ALRM0  = 12;
  localparam int W_PKA    = 19;
  localparam int W_PKB    = 20;
  localparam int W_CFG0   = 23;
  localparam int W_CFG1   = 24;
  localparam int W_PROT   = 28;
  localparam int W_COMMIT = 30;

  localparam logic [7:0]    CTRL_KEY   = 8'h43;
  localparam int            BIT_BUSY   = 6;
  localparam int            BIT_RELOAD = 5;
  localparam int            BIT_PKCLR  = 4;
  localparam logic [DW-1:0] PKA_MAGIC  = 16'hA357;
  localparam logic [DW-1:0] PKB_MAGIC  = 16'h67D2;
  localparam logic [DW-1:0] UNLOCK_1ST = 16'h9136;
  localparam logic [DW-1:0] UNLOCK_2ND = 16'h586A;

  typedef enum logic [1:0] {LK_LOCKED, LK_HALF, LK_OPEN} lock_e;

  function automatic logic is_timealarm(int w);
    return (w >= W_TIME0 && w < W_TIME0 + FIELDS) ||
           (w >= W_ALRM0 && w < W_ALRM0 + FIELDS);
  endfunction

  function automatic logic is_pk(int w);
    return (w == W_PKA) || (w == W_PKB);
  endfunction

  function automatic logic is_stored(int w);
    return is_timealarm(w) || is_pk(w) || w == W_CFG0 || w == W_CFG1 || w == W_PROT;
  endfunction

  function automatic logic write_allowed(int w, logic unlocked, logic cfg_ok);
    if (is_timealarm(w)) return unlocked;
    if (is_pk(w))        return cfg_ok;
    return 1'b1;
  endfunction

  function automatic logic keys_valid(logic [DW-1:0] a, logic [DW-1:0] b);
    return (a == PKA_MAGIC) && (b == PKB_MAGIC);
  endfunction

  function automatic lock_e lock_next(lock_e cur, logic [DW-1:0] v);
    if (v == UNLOCK_1ST)                      return LK_HALF;
    if (cur == LK_HALF && v == UNLOCK_2ND)    return LK_OPEN;
    return LK_LOCKED;
  endfunction
endpackage

// File: rtl/rtc_fe_decode.sv
module rtc_fe_decode #(
  parameter int AW = 7,
  localparam int NWORDS = 2 ** (AW - 2)
) (
  input  logic [AW-1:0]     addr,
  output logic [NWORDS-1:0] sel,
  output logic [AW-3:0]     widx
);
  assign widx = addr[AW-1:2];
  always_comb begin
    sel = '0;
    if (addr[1:0] == 2'b00) sel[widx] = 1'b1;
  end
endmodule

// File: rtl/rtc_fe_commit.sv
module rtc_fe_commit #(
  parameter int BUSY_CYCLES = 4,
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic busy,
  output logic start,
  output logic done
);
  logic [CW-1:0] cnt_q;

  assign busy  = (cnt_q != '0);
  assign start = req && !busy;
  assign done  = (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (start) cnt_q <= CW'(BUSY_CYCLES);
    else if (busy)  cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/rtc_fe_unlock.sv
module rtc_fe_unlock
  import rtc_fe_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eval,
  input  logic [DW-1:0] value,
  output logic          unlocked
);
  lock_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= LK_LOCKED;
    else if (eval) state_q <= lock_next(state_q, value);
  end

  assign unlocked = (state_q == LK_OPEN);
endmodule

// File: rtl/rtc_fe_top.sv
module rtc_fe_top
  import rtc_fe_pkg::*;
#(
  parameter int AW = 7,
  parameter int BUSY_CYCLES = 4,
  localparam int NWORDS = 2 ** (AW - 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          commit_busy,
  output logic          power_lost,
  output logic          wr_unlocked
);
  logic [NWORDS-1:0]         sel;
  logic [AW-3:0]             widx;
  logic [NWORDS-1:0]         wr_word;
  logic [NWORDS-1:0][DW-1:0] hold_v;
  logic [NWORDS-1:0][DW-1:0] act_v;
  logic [NWORDS-1:0]         accept_v;

  // named events for the checker
  logic ctrl_ok, pk_clear, reload_req, commit_req, commit_start, commit_done;
  logic prot_dirty_q, cfg_ok_q;
  logic [1:0] cfg_seen_q;

  rtc_fe_decode #(.AW(AW)) u_dec (.addr(bus_addr), .sel(sel), .widx(widx));

  assign wr_word    = bus_wr ? sel : '0;
  assign ctrl_ok    = wr_word[W_CTRL] && (bus_wdata[15:8] == CTRL_KEY);
  assign pk_clear   = ctrl_ok && bus_wdata[BIT_PKCLR];
  assign reload_req = ctrl_ok && bus_wdata[BIT_RELOAD];
  assign commit_req = wr_word[W_COMMIT] && (bus_wdata == DW'(1));

  rtc_fe_commit #(.BUSY_CYCLES(BUSY_CYCLES)) u_commit (
    .clk(clk), .rst_n(rst_n), .req(commit_req),
    .busy(commit_busy), .start(commit_start), .done(commit_done)
  );

  rtc_fe_unlock u_lock (
    .clk(clk), .rst_n(rst_n), .eval(commit_done && prot_dirty_q),
    .value(hold_v[W_PROT]), .unlocked(wr_unlocked)
  );

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    if (is_stored(w)) begin : g_reg
      logic [DW-1:0] h_q, a_q;
      assign accept_v[w] = wr_word[w] && write_allowed(w, wr_unlocked, cfg_ok_q);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          h_q <= '0;
          a_q <= '0;
        end else if (pk_clear && is_pk(w)) begin
          h_q <= '0;
          a_q <= '0;
        end else begin
          if (accept_v[w])     h_q <= bus_wdata;
          else if (reload_req) h_q <= a_q;
          if (commit_done)     a_q <= h_q;
        end
      end
      assign hold_v[w] = h_q;
      assign act_v[w]  = a_q;
    end else begin : g_none
      assign accept_v[w] = 1'b0;
      assign hold_v[w]   = '0;
      assign act_v[w]    = '0;
    end
  end

  // staging bookkeeping for the protection and power-key gates
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_dirty_q <= 1'b0;
      cfg_seen_q   <= 2'b00;
      cfg_ok_q     <= 1'b0;
    end else begin
      if (accept_v[W_PROT])  prot_dirty_q <= 1'b1;
      else if (commit_done)  prot_dirty_q <= 1'b0;
      if (accept_v[W_CFG0])  cfg_seen_q[0] <= 1'b1;
      if (accept_v[W_CFG1])  cfg_seen_q[1] <= 1'b1;
      if (commit_done && cfg_seen_q == 2'b11) cfg_ok_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = act_v[widx];
    if (widx == (AW-2)'(W_CTRL)) begin
      bus_rdata = '0;
      bus_rdata[BIT_BUSY] = commit_busy;
    end
  end

  assign power_lost = !keys_valid(act_v[W_PKA], act_v[W_PKB]);
endmodule

// File: rtl/rtc_fe_sva.sv
module rtc_fe_sva
  import rtc_fe_pkg::*;
#(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          commit_busy,
  input logic          power_lost,
  input logic          wr_unlocked,
  input logic          commit_start,
  input logic          commit_done
);
  logic bad_ctrl;
  assign bad_ctrl = bus_wr && bus_addr == '0 && bus_wdata[15:8] != CTRL_KEY;

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_start |=> commit_busy);

  assert_no_early_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_busy && !commit_done) |=> commit_busy);

  assert_unlock_on_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_unlocked) |-> $past(commit_done));

  assert_keys_need_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(power_lost) |-> $past(commit_done));

  assert_bad_key_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_ctrl && !commit_done) |=> $stable(power_lost));
endmodule

bind rtc_fe_top rtc_fe_sva #(.AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .commit_busy(commit_busy), .power_lost(power_lost),
  .wr_unlocked(wr_unlocked), .commit_start(commit_start), .commit_done(commit_done)
);

// File: tb/rtc_fe_top_tb.sv
`timescale 1ns/1ps
module rtc_fe_top_tb;
  localparam int AW = 7;
  localparam int BUSY = 4;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic commit_busy, power_lost, wr_unlocked;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  rtc_fe_top #(.AW(AW), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .commit_busy(commit_busy),
    .power_lost(power_lost), .wr_unlocked(wr_unlocked)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [6:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic commit();
    wr(7'h78, 16'h0001);
    repeat (BUSY) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 busy", 16'(commit_busy), 0);
    check("R1 unlocked", 16'(wr_unlocked), 0);
    check("R1 power_lost", 16'(power_lost), 1);
    rd(7'h10, d); check("R1 time0", d, 0);
    rd(7'h4C, d); check("R1 pkA", d, 0);
  endtask

  task automatic t_busy();
    logic [15:0] d;
    wr(7'h78, 16'h0002);
    check("R2 non-one value ignored", 16'(commit_busy), 0);
    wr(7'h78, 16'h0001);
    for (int i = 1; i <= BUSY; i++) begin
      if (i > 1) @(negedge clk);
      check("R2 busy during window", 16'(commit_busy), 1);
    end
    @(negedge clk);
    check("R2 busy falls", 16'(commit_busy), 0);
    wr(7'h78, 16'h0001);
    bus_addr = 7'h00; #1 d = bus_rdata;
    check("R2 ctrl bit6", 16'(d[6]), 1);
    wr(7'h78, 16'h0001);          // lands on 2nd busy cycle
    @(negedge clk);
    check("R3 still busy", 16'(commit_busy), 1);
    @(negedge clk);
    check("R3 not extended", 16'(commit_busy), 0);
  endtask

  task automatic t_power_keys();
    logic [15:0] d;
    wr(7'h4C, 16'hA357); wr(7'h50, 16'h67D2); commit();
    check("R11 keys dropped before cfg", 16'(power_lost), 1);
    rd(7'h4C, d); check("R11 pkA stays 0", d, 0);
    wr(7'h5C, 16'h4848); wr(7'h60, 16'h0048); commit();
    wr(7'h4C, 16'hA357); wr(7'h50, 16'h1234); commit();
    check("R10 one key wrong", 16'(power_lost), 1);
    rd(7'h4C, d); check("R11 pkA accepted", d, 16'hA357);
    wr(7'h50, 16'h67D2); commit();
    check("R10 both keys valid", 16'(power_lost), 0);
  endtask

  task automatic t_lock();
    logic [15:0] d;
    wr(7'h10, 16'h0015); commit();
    rd(7'h10, d); check("R7 locked write dropped", d, 0);
    wr(7'h70, 16'h586A); commit(); wr(7'h70, 16'h9136); commit();
    check("R6 reverse order", 16'(wr_unlocked), 0);
    wr(7'h70, 16'h9136); commit(); wr(7'h70, 16'h1111); commit();
    check("R6 wrong second word", 16'(wr_unlocked), 0);
    wr(7'h30, 16'h0007); commit();
    rd(7'h30, d); check("R7 alarm dropped", d, 0);
    wr(7'h70, 16'h9136); commit();
    check("R5 half way", 16'(wr_unlocked), 0);
    wr(7'h70, 16'h586A); commit();
    check("R5 unlocked", 16'(wr_unlocked), 1);
  endtask

  task automatic t_stage();
    logic [15:0] d;
    wr(7'h10, 16'h002A);
    rd(7'h10, d); check("R4 staged not visible", d, 0);
    commit();
    rd(7'h10, d); check("R4 visible after commit", d, 16'h002A);
    wr(7'h48, 16'h0055); commit();
    rd(7'h48, d); check("R4 alarm last field", d, 16'h0055);
    wr(7'h10, 16'h0033); wr(7'h00, 16'h4320); commit();
    rd(7'h10, d); check("R9 reload discards", d, 16'h002A);
  endtask

  task automatic t_ctrl();
    logic [15:0] d;
    wr(7'h00, 16'h4410);
    check("R8 bad key ignored", 16'(power_lost), 0);
    wr(7'h00, 16'h4310);
    check("R8 clear keys", 16'(power_lost), 1);
    rd(7'h50, d); check("R8 pkB cleared", d, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_busy();
        t_power_keys();
        t_lock();
        t_stage();
        t_ctrl();
      end
      begin
        repeat (20000) @(negedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule